// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a watchdog that counts a selectable time-out period. Software must service it before the period runs out, and a service consists of two fixed byte writes: 0x55 and then 0xAA. If windowing is turned on, every service write has to land in the final quarter of the period. A write that comes too early, a byte that does not match what the sequence expects next, or a count that runs to the end of the period all produce a one-cycle reset request.

Each reset request also sets a sticky cause flag. After the system reset finishes, the reset controller reads that flag to learn that the watchdog started the reset, and it can then clear the flag. Software writes the configuration byte exactly once after each reset. That byte sets the period and the window mode, and any later configuration write is dropped.

"Count" below means the number of clock edges since the last restart. A restart happens on the accepted configuration write, on an accepted 0xAA, on every reset request, and on reset.

Top module: `win_watchdog`

## Requirements
- R1: When porN is low, rstReq and wdtCause go to 0. When porN or rstN is low, the counter stops, the configuration unlocks and the service sequence returns to expecting 0x55.
- R2: A cfgWe write takes wrData[2:0] as the period code and wrData[7] as the window enable. Only the first cfgWe write after a reset is accepted, and later writes change nothing.
- R3: Period code k from 1 to 7 selects P = 2^(MIN_EXP + ((k-1)*EXP_SPAN)/6) cycles. Code 0 disables the watchdog: rstReq never rises and service writes are ignored.
- R4: If no service arrives, rstReq is high in the cycle that follows clock edge r+P, where r is the edge of the last restart.
- R5: A svcWe write of 0x55 followed by a svcWe write of 0xAA restarts the count, so the next expiry falls P edges after the 0xAA edge.
- R6: A 0x55 on its own does not restart the count.
- R7: A service byte that is not the one the sequence expects next (0x55 first, 0xAA second) raises rstReq in the cycle after that write.
- R8: When the window is enabled, a service write whose count is below P - P/4 raises rstReq in the next cycle. A write at count P - P/4 or higher is accepted. When the window is disabled, service writes are accepted at any count.
- R9: wdtCause is set with every rstReq and stays set through rstN. Only porN or causeClr clears it.
- R10: Each rstReq event lasts exactly one cycle and restarts the count. A watchdog left unserviced fires again every P cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porN | input | 1 | Power-on reset, active low, synchronous; clears everything including the cause flag |
| rstN | input | 1 | System reset, active low, synchronous; keeps the cause flag |
| cfgWe | input | 1 | Configuration write strobe |
| svcWe | input | 1 | Service register write strobe |
| wrData | input | 8 | Write data shared by both strobes |
| causeClr | input | 1 | Read-and-clear of the cause flag by the reset controller |
| rstReq | output | 1 | One-cycle watchdog reset request |
| wdtCause | output | 1 | Latched flag: the watchdog requested a reset |

## Verification
The bench builds the block with MIN_EXP = 4 and EXP_SPAN = 6, so the seven codes give periods from 16 to 1024 cycles. With periods that short, the bench can run repeated expiries, place writes exactly on either side of the window edge (count 47 is rejected and count 48 is accepted for P = 64), and reach the longest code, all in a few thousand cycles. A scoreboard holds the exact cycle of every reset request it predicts. Any extra, missing or late pulse is reported against the requirement that predicted it.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

  // Strobes from control to the counter datapath
  typedef struct packed {
    logic cntRun;
    logic cntClear;
  } wdgStrobe_t;

  typedef enum logic {
    SEQ_WAIT_FIRST  = 1'b0,
    SEQ_WAIT_SECOND = 1'b1
  } svcSeq_e;

  localparam logic [7:0] SVC_KEY_FIRST  = 8'h55;
  localparam logic [7:0] SVC_KEY_SECOND = 8'hAA;
  localparam int unsigned SEL_STEPS = 6;

  // Exponent of the period for a nonzero code
  function automatic int unsigned periodExp(input logic [2:0] sel,
                                            input int unsigned minExp,
                                            input int unsigned spanExp);
    int unsigned idx;
    idx = (sel == 3'd0) ? 32'd0 : (32'(sel) - 32'd1);
    return minExp + (idx * spanExp) / SEL_STEPS;
  endfunction

endpackage

// File: rtl/wdg_datapath.sv
module wdg_datapath
  import wdg_pkg::*;
#(
  parameter int unsigned MIN_EXP  = 14,
  parameter int unsigned EXP_SPAN = 10
) (
  input  logic       clk,
  input  logic       rstN,
  input  wdgStrobe_t strb,
  input  logic [2:0] perSel,
  output logic       atLast,
  output logic       inWindow
);

  localparam int unsigned CW = MIN_EXP + EXP_SPAN + 1;

  logic [CW-1:0] cnt;
  logic [CW-1:0] periodLen;
  logic [CW-1:0] lastVal;
  logic [CW-1:0] winStart;

  always_comb begin
    periodLen = CW'(1) << periodExp(perSel, MIN_EXP, EXP_SPAN);
    lastVal   = periodLen - CW'(1);
    winStart  = periodLen - (periodLen >> 2);
  end

  always_ff @(posedge clk) begin
    if (!rstN)              cnt <= '0;
    else if (strb.cntClear) cnt <= '0;
    else if (strb.cntRun)   cnt <= cnt + CW'(1);
  end

  assign atLast   = (cnt == lastVal);
  assign inWindow = (cnt >= winStart);

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    strb.cntRun |-> (cnt <= lastVal)) else $error("count beyond period"); // R4

endmodule

// File: rtl/wdg_control.sv
module wdg_control
  import wdg_pkg::*;
(
  input  logic       clk,
  input  logic       porN,
  input  logic       sysRstN,
  input  logic       cfgWe,
  input  logic       svcWe,
  input  logic [7:0] wrData,
  input  logic       causeClr,
  input  logic       atLast,
  input  logic       inWindow,
  output wdgStrobe_t strb,
  output logic [2:0] perSel,
  output logic       rstReq,
  output logic       wdtCause
);

  logic    cfgLocked;
  logic    winEn;
  logic    active;
  logic    violation;
  logic    pairDone;
  logic    fire;
  svcSeq_e seqQ, seqNext;

  assign active = cfgLocked && (perSel != 3'd0);

  always_comb begin
    violation = 1'b0;
    pairDone  = 1'b0;
    seqNext   = seqQ;
    if (active && svcWe) begin
      if (winEn && !inWindow) begin
        violation = 1'b1;
      end else if (seqQ == SEQ_WAIT_FIRST && wrData == SVC_KEY_FIRST) begin
        seqNext = SEQ_WAIT_SECOND;
      end else if (seqQ == SEQ_WAIT_SECOND && wrData == SVC_KEY_SECOND) begin
        seqNext  = SEQ_WAIT_FIRST;
        pairDone = 1'b1;
      end else begin
        violation = 1'b1;
      end
    end
    fire = violation || (active && atLast && !pairDone);
    if (fire) seqNext = SEQ_WAIT_FIRST;
    strb.cntRun   = active;
    strb.cntClear = pairDone || fire;
  end

  always_ff @(posedge clk) begin
    if (!sysRstN) begin
      cfgLocked <= 1'b0;
      perSel    <= 3'd0;
      winEn     <= 1'b0;
      seqQ      <= SEQ_WAIT_FIRST;
      rstReq    <= 1'b0;
    end else begin
      if (cfgWe && !cfgLocked) begin
        perSel    <= wrData[2:0];
        winEn     <= wrData[7];
        cfgLocked <= 1'b1;
      end
      seqQ   <= seqNext;
      rstReq <= fire;
    end
  end

  always_ff @(posedge clk) begin
    if (!porN)         wdtCause <= 1'b0;
    else if (fire)     wdtCause <= 1'b1;
    else if (causeClr) wdtCause <= 1'b0;
  end

  AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!sysRstN)
    (cfgLocked && $past(cfgLocked)) |-> ($stable(perSel) && $stable(winEn)))
    else $error("config changed after lock"); // R2

  AST_ZERO_SILENT: assert property (@(posedge clk) disable iff (!sysRstN)
    (cfgLocked && perSel == 3'd0) |=> !rstReq) else $error("disabled watchdog fired"); // R3

  AST_REQ_WHILE_ACTIVE: assert property (@(posedge clk) disable iff (!sysRstN)
    rstReq |-> $past(active)) else $error("request while inactive"); // R3

  AST_EARLY_WRITE: assert property (@(posedge clk) disable iff (!sysRstN)
    (active && svcWe && winEn && !inWindow) |=> rstReq) else $error("early write missed"); // R8

  AST_CAUSE_WITH_REQ: assert property (@(posedge clk) disable iff (!porN)
    rstReq |-> wdtCause) else $error("cause flag not set"); // R9

endmodule

// File: rtl/win_watchdog.sv
module win_watchdog
  import wdg_pkg::*;
#(
  parameter int unsigned MIN_EXP  = 14,
  parameter int unsigned EXP_SPAN = 10
) (
  input  logic       clk,
  input  logic       porN,
  input  logic       rstN,
  input  logic       cfgWe,
  input  logic       svcWe,
  input  logic [7:0] wrData,
  input  logic       causeClr,
  output logic       rstReq,
  output logic       wdtCause
);

  logic       sysRstN;
  wdgStrobe_t strb;
  logic [2:0] perSel;
  logic       atLast;
  logic       inWindow;

  assign sysRstN = rstN && porN;

  wdg_control u_ctl (
    .clk      (clk),
    .porN     (porN),
    .sysRstN  (sysRstN),
    .cfgWe    (cfgWe),
    .svcWe    (svcWe),
    .wrData   (wrData),
    .causeClr (causeClr),
    .atLast   (atLast),
    .inWindow (inWindow),
    .strb     (strb),
    .perSel   (perSel),
    .rstReq   (rstReq),
    .wdtCause (wdtCause)
  );

  wdg_datapath #(
    .MIN_EXP  (MIN_EXP),
    .EXP_SPAN (EXP_SPAN)
  ) u_dp (
    .clk      (clk),
    .rstN     (sysRstN),
    .strb     (strb),
    .perSel   (perSel),
    .atLast   (atLast),
    .inWindow (inWindow)
  );

endmodule

// File: tb/sim_win_watchdog.sv
`timescale 1ns/1ps
module sim_win_watchdog;

  logic       clk = 1'b0;
  logic       porN = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgWe = 1'b0;
  logic       svcWe = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic       causeClr = 1'b0;
  logic       rstReq;
  logic       wdtCause;

  int cyc = 0;
  int checks = 0;
  int failures = 0;
  int pulseCount = 0;

  typedef struct {
    int    when;
    string req;
  } expItem_t;
  expItem_t sb[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  win_watchdog #(.MIN_EXP(4), .EXP_SPAN(6)) u0 (
    .clk(clk), .porN(porN), .rstN(rstN), .cfgWe(cfgWe), .svcWe(svcWe),
    .wrData(wrData), .causeClr(causeClr), .rstReq(rstReq), .wdtCause(wdtCause)
  );

  // Monitor: each observed pulse is matched with the oldest prediction
  always @(negedge clk) begin
    if (rstReq) begin
      expItem_t it;
      pulseCount++;
      checks++;
      if (sb.size() == 0) begin
        failures++;
        $display("FAIL R10 unexpected rstReq at cycle %0d (expected none)", cyc);
      end else begin
        it = sb.pop_front();
        if (it.when != cyc) begin
          failures++;
          $display("FAIL %s rstReq at cycle %0d, expected cycle %0d", it.req, cyc, it.when);
        end
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic expectAt(input int when, input string req);
    expItem_t it;
    it.when = when;
    it.req = req;
    sb.push_back(it);
  endtask

  task automatic drained(input string req);
    check(req, sb.size(), 0);
    sb.delete();
  endtask

  task automatic waitTo(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic wrCfg(input logic [7:0] d, output int e);
    cfgWe = 1'b1; wrData = d; e = cyc + 1;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic wrSvc(input logic [7:0] d, output int e);
    svcWe = 1'b1; wrData = d; e = cyc + 1;
    @(negedge clk);
    svcWe = 1'b0;
  endtask

  task automatic pulseRst();
    rstN = 1'b0; @(negedge clk); rstN = 1'b1; @(negedge clk);
  endtask

  task automatic pulseClr();
    causeClr = 1'b1; @(negedge clk); causeClr = 1'b0; @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL R1 watchdog expired at cycle %0d (expected finish)", cyc);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int e, e2, r, a, v, s, x, base;
    repeat (3) @(negedge clk);
    porN = 1'b1; rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1 rstReq after reset", rstReq, 0);
    check("R1 wdtCause after reset", wdtCause, 0);

    // R4 R10: code 1 (P=16), no service, repeated expiry
    wrCfg(8'h01, e);
    expectAt(e + 16, "R4");
    expectAt(e + 32, "R10");
    waitTo(e + 34);
    drained("R4 R10 pending");
    check("R9 cause set", wdtCause, 1);
    pulseRst();
    check("R9 cause kept over rstN", wdtCause, 1);
    pulseClr();
    check("R9 cause cleared", wdtCause, 0);

    // R5 R6 R8: code 2 (P=32), no window, early service accepted
    wrCfg(8'h02, e);
    waitTo(e + 2);
    wrSvc(8'h55, a);
    wrSvc(8'hAA, s);
    expectAt(s + 32, "R5,R6");
    waitTo(s + 9);
    wrSvc(8'h55, x);
    waitTo(s + 33);
    drained("R5 R6 pending");
    pulseRst();

    // R7: wrong byte, and 0xAA out of order
    wrCfg(8'h02, e);
    waitTo(e + 4);
    expectAt(cyc + 1, "R7");
    wrSvc(8'h33, v);
    waitTo(v + 3);
    expectAt(cyc + 1, "R7");
    wrSvc(8'hAA, x);
    expectAt(x + 32, "R10");
    waitTo(x + 33);
    drained("R7 pending");
    pulseRst();

    // R8: windowed, code 3 (P=64), window from count 48
    wrCfg(8'h83, e);
    waitTo(e + 19);
    expectAt(cyc + 1, "R8");
    wrSvc(8'h55, r);
    waitTo(r + 49);
    wrSvc(8'h55, x);
    wrSvc(8'hAA, a);
    waitTo(a + 47);
    expectAt(cyc + 1, "R8");
    wrSvc(8'h55, v);
    waitTo(v + 48);
    wrSvc(8'h55, x);
    wrSvc(8'hAA, s);
    expectAt(s + 64, "R8");
    waitTo(s + 65);
    drained("R8 pending");
    pulseRst();

    // R2: second config write ignored
    wrCfg(8'h01, e);
    wrCfg(8'h07, e2);
    expectAt(e + 16, "R2");
    waitTo(e + 17);
    drained("R2 pending");
    pulseRst();

    // R3: code 0 disables, services ignored, later config locked out
    pulseClr();
    check("R3 cause before idle run", wdtCause, 0);
    wrCfg(8'h00, e);
    wrSvc(8'h12, x);
    wrSvc(8'h55, x);
    base = pulseCount;
    waitTo(e + 1100);
    wrCfg(8'h01, x);
    waitTo(cyc + 40);
    check("R3 pulses while disabled", pulseCount - base, 0);
    check("R3 cause while disabled", wdtCause, 0);
    pulseRst();

    // R3: longest code 7 (P=1024)
    wrCfg(8'h07, e);
    expectAt(e + 1024, "R3");
    waitTo(e + 1025);
    drained("R3 pending");
    check("R9 cause after code 7", wdtCause, 1);

    // R1 R9: power-on reset clears the flag
    porN = 1'b0; @(negedge clk); porN = 1'b1; @(negedge clk);
    check("R1 cause after porN", wdtCause, 0);
    check("R1 rstReq after porN", rstReq, 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule